// File: doc/BRIEF.md
# Two-Level Mixed-Radix Prefix Adder (64-bit)

This block adds two 64-bit operands and a one-bit carry-in, giving a 64-bit sum and a carry-out. The carry logic is a parallel-prefix network. Every bit first forms a generate term (both operand bits set) and a propagate term (operand bits differ). Adjacent bit ranges are then merged into group terms. The network uses combining cells that take two, three or four neighbouring ranges at once.

The operands are cut into four 16-bit slices. Each slice builds all of its internal prefixes in three cell levels:
- Level one: four-input cells over each nibble.
- Level two: a nibble-prefix stage.
- Level three: two-input fix-up cells.

A small second-level network takes the group term of each whole slice, together with the carry-in, and gives every slice its incoming carry. It also gives the final carry-out.

A single register stage sits on the result, with a valid flag that travels alongside it. The result appears one clock after the operands are offered with the valid input high. When the valid input is low, the registered result keeps its previous value.

Top module: `pfx_add64`

## Requirements
- R1: One clock after a cycle with `in_valid` high, `sum` equals bits 63..0 of the 65-bit value a + b + cin for the operands presented in that cycle.
- R2: In the same cycle, `cout` equals bit 64 of that 65-bit value.
- R3: `out_valid` equals the value `in_valid` had one clock earlier. While `rst_n` is low, `out_valid`, `sum` and `cout` are all 0.
- R4: A cycle with `in_valid` low leaves `sum` and `cout` unchanged on the next clock, whatever the operands and `cin` carry.
- R5: a = all ones, b = 0 and cin = 1 gives sum = 0 and cout = 1. The same operands with cin = 0 give sum = all ones and cout = 0.
- R6: A carry born below any slice boundary (bit 16, 32 or 48) reaches the slice above it. For k in 1..3, a = 2^(16k) - 1, b = 1 and cin = 0 gives sum = 2^(16k) and cout = 0.
- R7: Alternating patterns: a = 0x5555...5, b = 0xAAAA...A gives sum = all ones and cout = 0 with cin = 0, and sum = 0 and cout = 1 with cin = 1.
- R8: The carry-in has the weight of bit 0. a = 0, b = 0 and cin = 1 gives sum = 1 and cout = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operands valid this cycle |
| a | input | 64 | First operand |
| b | input | 64 | Second operand |
| cin | input | 1 | Carry-in |
| out_valid | output | 1 | Registered result valid |
| sum | output | 64 | Registered sum |
| cout | output | 1 | Registered carry-out |

## Verification
The adder has no internal state across cycles, so a wrong group term anywhere in the tree shows up at the ports one clock after the operands that exercise it. The symptom is a sum bit that is wrong, or a carry-out that is wrong. A bad nibble or slice prefix only shows when a carry has to cross that particular boundary. For that reason, the bench drives carry chains that end just above every nibble and slice edge, along with all-ones and alternating operands and random vectors. A behavioural 65-bit addition in the bench is compared with the outputs on every clock, together with the valid flag and the hold behaviour.

// File: rtl/pfx_pkg.sv
package pfx_pkg;
    localparam int ADD_W   = 64;
    localparam int SLICE_W = 16;
    localparam int NIB_W   = 4;
    localparam int NSLICE  = ADD_W / SLICE_W;
    localparam int NNIB    = SLICE_W / NIB_W;

    typedef struct packed {
        logic g;
        logic p;
    } gp_t;
endpackage

// File: rtl/pfx_gp_cell.sv
// Merges RADIX adjacent ranges; index 0 is the least significant range.
module pfx_gp_cell
    import pfx_pkg::*;
#(
    parameter int RADIX = 2
) (
    input  gp_t grp [RADIX],
    output gp_t res
);
    always_comb begin
        res = grp[0];
        for (int i = 1; i < RADIX; i++) begin
            res.g = grp[i].g | (grp[i].p & res.g);
            res.p = grp[i].p & res.p;
        end
    end
endmodule

// File: rtl/pfx_slice.sv
// One slice: per-bit terms, three levels of prefix cells, sum bits.
module pfx_slice
    import pfx_pkg::*;
(
    input  logic [SLICE_W-1:0] a,
    input  logic [SLICE_W-1:0] b,
    input  logic               cin,
    output logic [SLICE_W-1:0] sum,
    output gp_t                grp
);
    gp_t bit_gp  [SLICE_W];
    gp_t loc_pre [SLICE_W];   // prefix within own nibble
    gp_t nib_pre [NNIB];      // prefix of whole nibbles from bit 0
    gp_t full_pre[SLICE_W];   // prefix [i:0] within slice
    logic [SLICE_W-1:0] carry;

    for (genvar i = 0; i < SLICE_W; i++) begin : g_bits
        assign bit_gp[i].g = a[i] & b[i];
        assign bit_gp[i].p = a[i] ^ b[i];
    end

    // Level one: in-nibble prefixes with radix 2, 3, 4 cells
    for (genvar n = 0; n < NNIB; n++) begin : g_nib
        for (genvar j = 0; j < NIB_W; j++) begin : g_pos
            if (j == 0) begin : g_pass
                assign loc_pre[n*NIB_W] = bit_gp[n*NIB_W];
            end else begin : g_cell
                gp_t ins [j+1];
                for (genvar k = 0; k <= j; k++) begin : g_in
                    assign ins[k] = bit_gp[n*NIB_W + k];
                end
                pfx_gp_cell #(.RADIX(j+1)) u_cell (
                    .grp(ins),
                    .res(loc_pre[n*NIB_W + j])
                );
            end
        end
    end

    // Level two: prefixes over whole nibbles
    for (genvar m = 0; m < NNIB; m++) begin : g_npre
        if (m == 0) begin : g_pass
            assign nib_pre[0] = loc_pre[NIB_W-1];
        end else begin : g_cell
            gp_t ins [m+1];
            for (genvar k = 0; k <= m; k++) begin : g_in
                assign ins[k] = loc_pre[k*NIB_W + NIB_W-1];
            end
            pfx_gp_cell #(.RADIX(m+1)) u_cell (
                .grp(ins),
                .res(nib_pre[m])
            );
        end
    end

    // Level three: radix-2 fix-up of bits in upper nibbles
    for (genvar i = 0; i < SLICE_W; i++) begin : g_fix
        if (i < NIB_W) begin : g_low
            assign full_pre[i] = loc_pre[i];
        end else if ((i % NIB_W) == NIB_W-1) begin : g_top
            assign full_pre[i] = nib_pre[i / NIB_W];
        end else begin : g_cell
            gp_t ins [2];
            assign ins[0] = nib_pre[i/NIB_W - 1];
            assign ins[1] = loc_pre[i];
            pfx_gp_cell #(.RADIX(2)) u_cell (
                .grp(ins),
                .res(full_pre[i])
            );
        end
    end

    // Post-processing
    for (genvar i = 0; i < SLICE_W; i++) begin : g_sum
        if (i == 0) begin : g_c0
            assign carry[0] = cin;
        end else begin : g_ci
            assign carry[i] = full_pre[i-1].g | (full_pre[i-1].p & cin);
        end
        assign sum[i] = bit_gp[i].p ^ carry[i];
    end

    assign grp = full_pre[SLICE_W-1];
endmodule

// File: rtl/pfx_carry_net.sv
// Second level: incoming carry per slice and the final carry-out.
module pfx_carry_net
    import pfx_pkg::*;
(
    input  gp_t  slice_grp [NSLICE],
    input  logic cin,
    output logic [NSLICE-1:0] slice_cin,
    output logic cout
);
    gp_t cin_gp;
    assign cin_gp = '{g: cin, p: 1'b0};

    for (genvar k = 0; k < NSLICE; k++) begin : g_slice
        if (k == 0) begin : g_first
            assign slice_cin[0] = cin;
        end else begin : g_cell
            gp_t ins [k+1];
            gp_t res;
            assign ins[0] = cin_gp;
            for (genvar m = 1; m <= k; m++) begin : g_in
                assign ins[m] = slice_grp[m-1];
            end
            pfx_gp_cell #(.RADIX(k+1)) u_cell (
                .grp(ins),
                .res(res)
            );
            assign slice_cin[k] = res.g;
        end
    end

    gp_t out_ins [2];
    gp_t out_res;
    assign out_ins[0] = '{g: slice_cin[NSLICE-1], p: 1'b0};
    assign out_ins[1] = slice_grp[NSLICE-1];
    pfx_gp_cell #(.RADIX(2)) u_out (
        .grp(out_ins),
        .res(out_res)
    );
    assign cout = out_res.g;
endmodule

// File: rtl/pfx_add64_core.sv
module pfx_add64_core
    import pfx_pkg::*;
(
    input  logic [ADD_W-1:0] a,
    input  logic [ADD_W-1:0] b,
    input  logic             cin,
    output logic [ADD_W-1:0] sum,
    output logic             cout
);
    gp_t               slice_grp [NSLICE];
    logic [NSLICE-1:0] slice_cin;

    for (genvar s = 0; s < NSLICE; s++) begin : g_slice
        pfx_slice u_slice (
            .a  (a[s*SLICE_W +: SLICE_W]),
            .b  (b[s*SLICE_W +: SLICE_W]),
            .cin(slice_cin[s]),
            .sum(sum[s*SLICE_W +: SLICE_W]),
            .grp(slice_grp[s])
        );
    end

    pfx_carry_net u_carry (
        .slice_grp(slice_grp),
        .cin      (cin),
        .slice_cin(slice_cin),
        .cout     (cout)
    );
endmodule

// File: rtl/pfx_add64.sv
module pfx_add64
    import pfx_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [ADD_W-1:0] a,
    input  logic [ADD_W-1:0] b,
    input  logic             cin,
    output logic             out_valid,
    output logic [ADD_W-1:0] sum,
    output logic             cout
);
    logic [ADD_W-1:0] sum_c;
    logic             cout_c;

    pfx_add64_core u_core (
        .a   (a),
        .b   (b),
        .cin (cin),
        .sum (sum_c),
        .cout(cout_c)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            sum       <= '0;
            cout      <= 1'b0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                sum  <= sum_c;
                cout <= cout_c;
            end
        end
    end
endmodule

// File: rtl/pfx_add64_chk.sv
module pfx_add64_chk
    import pfx_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic [ADD_W-1:0] a,
    input logic [ADD_W-1:0] b,
    input logic             cin,
    input logic             out_valid,
    input logic [ADD_W-1:0] sum,
    input logic             cout
);
    logic [ADD_W:0] ref_add;
    assign ref_add = {1'b0, a} + {1'b0, b} + {{ADD_W{1'b0}}, cin};

    p_sum_r1: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> sum == $past(ref_add[ADD_W-1:0]));

    p_carry_r2: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> cout == $past(ref_add[ADD_W]));

    p_valid_r3: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> out_valid == $past(in_valid));

    p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(sum) && $stable(cout));

    p_ones_r5: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && (&a) && (b == '0) && cin |=> (sum == '0) && cout);

    p_cin_r8: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && (a == '0) && (b == '0) && cin |=> (sum == 1) && !cout);
endmodule

bind pfx_add64 pfx_add64_chk u_chk (.*);

// File: tb/pfx_add64_bench.sv
module pfx_add64_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [63:0] a = '0;
    logic [63:0] b = '0;
    logic        cin = 1'b0;
    logic        out_valid;
    logic [63:0] sum;
    logic        cout;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    logic [64:0] m_res = '0;
    logic        m_valid = 1'b0;

    always #10 clk = ~clk;

    pfx_add64 u_pfx_add64 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
        .a(a), .b(b), .cin(cin),
        .out_valid(out_valid), .sum(sum), .cout(cout)
    );

    task automatic chk(input bit ok, input string tag,
                       input logic [64:0] act, input logic [64:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // One clock: drive, update the model at the edge, compare 5 ns later.
    task automatic cyc(input logic v, input logic [63:0] x, input logic [63:0] y,
                       input logic c, input string tag);
        @(negedge clk);
        in_valid = v; a = x; b = y; cin = c;
        @(posedge clk);
        if (v) m_res = {1'b0, x} + {1'b0, y} + {64'd0, c};
        m_valid = v;
        #5;
        chk(out_valid == m_valid, "R3 valid", {64'd0, out_valid}, {64'd0, m_valid});
        chk(sum == m_res[63:0], {tag, " sum"}, {1'b0, sum}, {1'b0, m_res[63:0]});
        chk(cout == m_res[64], {tag, " cout"}, {64'd0, cout}, {64'd0, m_res[64]});
    endtask

    initial begin
        #(20 * 200000);
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog expired");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        #35;
        chk({out_valid, cout, sum} == '0, "R3 reset", {cout, sum}, '0);
        rst_n = 1'b1;
        // R8: carry-in weight
        cyc(1, '0, '0, 1'b1, "R8");
        chk(sum == 64'd1 && !cout, "R8 explicit", {cout, sum}, 65'd1);
        // R5: all ones plus carry-in
        cyc(1, '1, '0, 1'b1, "R5 cin1");
        chk(sum == '0 && cout, "R5 explicit", {cout, sum}, {1'b1, 64'd0});
        cyc(1, '1, '0, 1'b0, "R5 cin0");
        // R4: idle cycles with changing inputs must hold
        cyc(0, 64'h1234, 64'hFFFF_0000_0000_0000, 1'b1, "R4 hold");
        cyc(0, '1, '1, 1'b1, "R4 hold");
        chk(sum == '1 && !cout, "R4 explicit", {cout, sum}, {1'b0, {64{1'b1}}});
        // R7: alternating patterns
        cyc(1, {16{4'h5}}, {16{4'hA}}, 1'b0, "R7 cin0");
        cyc(1, {16{4'h5}}, {16{4'hA}}, 1'b1, "R7 cin1");
        cyc(1, {16{4'hA}}, {16{4'hA}}, 1'b1, "R7 both A");
        // R6: chains ending at every slice boundary, and every nibble edge
        for (int k = 1; k < 4; k++) begin
            cyc(1, (64'd1 << (16*k)) - 1, 64'd1, 1'b0, "R6 slice");
            chk(sum == (64'd1 << (16*k)) && !cout, "R6 explicit",
                {cout, sum}, {1'b0, 64'd1 << (16*k)});
            cyc(1, (64'd1 << (16*k)) - 1, 64'd0, 1'b1, "R6 slice cin");
        end
        for (int k = 1; k < 16; k++) begin
            cyc(1, (64'd1 << (4*k)) - 1, 64'd1, 1'b0, "R6 nibble");
        end
        cyc(1, 64'h8000_0000_0000_0000, 64'h8000_0000_0000_0000, 1'b0, "R2 top");
        // R1/R2: random vectors, valid toggling
        for (int i = 0; i < 300; i++) begin
            logic [63:0] x, y;
            x = {$urandom(), $urandom()};
            y = {$urandom(), $urandom()};
            if (i % 5 == 0) y = ~x;
            cyc(($urandom() % 4) != 0, x, y, 1'($urandom()), "R1 R2 random");
        end
        // R3: reset clears result again
        @(negedge clk);
        rst_n = 1'b0;
        #2;
        chk({out_valid, cout, sum} == '0, "R3 reset again", {cout, sum}, '0);
        done = 1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule